// File: doc/BRIEF.md
# Multi-Mode Serial Receive Channel

This block is the receive half of a serial port. It turns a serial input line into bytes and runs in one of three framings: plain asynchronous frames with an optional parity bit, asynchronous frames that carry a ninth address/data marker bit, or clock-synchronous transfer that uses an external serial clock. Each completed byte is placed in a receive data register. A status set records that the register is full and whether the frame had a parity, overrun or framing fault.

Which faults can be reported depends on the mode, and so does the point at which a byte is committed. Asynchronous frames commit when the stop bit is sampled. A synchronous transfer commits on the eighth data bit, because it has no stop bit. The error flags and the full flag rise together in the same cycle. Whenever an error flag is set, the byte that arrived with it must be treated as invalid. Two level interrupt requests, one for a completed byte and one for a fault, are each gated by an enable input.

A host reads the byte by pulsing the read strobe, which empties the register. It clears the fault flags with a separate one-cycle strobe. In the asynchronous modes, bit timing comes from an oversampling tick at 16 times the bit rate.

Top module: `sio_rx`

## Requirements
- R1: With `mode`=2'b00 (2'b11 behaves the same) and parity off, a frame has a low start bit, eight data bits sent LSB first and one high stop bit, each lasting 16 `os_tick` pulses. When the stop bit is sampled, `rx_data` takes the byte and `rx_full` is set.
- R2: A low pulse on `rxd` that is high again before mid start bit (8 ticks) is rejected: no frame is received and `rx_full` stays clear.
- R3: With `mode`=2'b00 and `par_en`=1, a parity bit follows the data. When the count of ones over data and parity bit is odd while `par_odd`=0, or even while `par_odd`=1, `err_par` is set.
- R4: With `mode`=2'b01, a ninth bit follows the data and is stored in `addr_flag`. `err_par` is never set in this mode, whatever `par_en` is.
- R5: In either asynchronous mode, a low stop bit sets `err_frm` in the same cycle that `rx_full` is set.
- R6: With `mode`=2'b10, `rxd` is sampled on each rising edge of `sclk`, LSB first. After the eighth bit, the byte is committed and `rx_full` is set without any stop bit. `err_par` and `err_frm` are never set in this mode.
- R7: A byte that completes while `rx_full` is still set raises `err_ovr`. The unread byte stays in `rx_data` and the new byte is dropped.
- R8: A one-cycle `rd_pulse` clears `rx_full` and leaves the error flags unchanged.
- R9: A one-cycle `err_clr` clears `err_par`, `err_ovr` and `err_frm` and leaves `rx_full` unchanged.
- R10: `irq_rx` is high exactly when `ie_rx` and `rx_full` are both high. `irq_err` is high exactly when `ie_err` is high and at least one error flag is set.
- R11: After reset, `rx_data` is zero, all flags are clear and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 async, 01 async with address bit, 10 clock-synchronous, 11 as 00 |
| par_en | input | 1 | Parity bit present and checked (mode 00) |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial data line (idle high) |
| sclk | input | 1 | External serial clock for mode 10 |
| rd_pulse | input | 1 | Data register read strobe |
| err_clr | input | 1 | Error flag clear strobe |
| ie_rx | input | 1 | Receive-complete interrupt enable |
| ie_err | input | 1 | Receive-error interrupt enable |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive data register full |
| err_par | output | 1 | Parity error flag |
| err_ovr | output | 1 | Overrun error flag |
| err_frm | output | 1 | Framing error flag |
| addr_flag | output | 1 | Ninth bit of the last frame in mode 01 |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The bench sends a short low glitch. A receiver that does not confirm the start bit at mid-bit would assemble a garbage byte from it and set the full flag. It sends a frame whose ninth bit would fail the parity check while the parity enable is still set in address mode, and it checks parity and framing in synchronous mode. A design that took no account of the mode would raise `err_par` or `err_frm` there. It lets a second byte land on an unread one: a design that overwrote the register would show the new byte instead of the old one. It also applies each clear strobe and checks that only the flags that strobe owns are cleared.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    localparam int DW  = 8;
    localparam int OSR = 16;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_MPROC = 2'b01,
        MODE_SYNC  = 2'b10,
        MODE_RSVD  = 2'b11
    } rx_mode_e;

    typedef enum logic [1:0] {
        AS_IDLE,
        AS_START,
        AS_BITS,
        AS_STOP
    } as_state_e;

    // one completed frame as handed to the status logic
    typedef struct packed {
        logic [DW-1:0] data;
        logic          extra;
        logic          frm_bad;
    } frame_t;

    typedef struct packed {
        logic full;
        logic perr;
        logic ovr;
        logic ferr;
        logic addr;
    } status_t;

    // high when data plus parity bit does not match the selected sense
    function automatic logic parity_mismatch(input logic [DW-1:0] d,
                                             input logic pbit,
                                             input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

    function automatic logic is_async(input rx_mode_e m);
        return m != MODE_SYNC;
    endfunction

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sio_rx_async.sv
module sio_rx_async
    import sio_rx_pkg::*;
#(
    parameter int OS = OSR
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  logic   line,
    input  logic   extra_en,
    output logic   done,
    output frame_t frame
);
    localparam int TW   = $clog2(OS);
    localparam int BW   = $clog2(DW + 2);
    localparam logic [TW-1:0] T_HALF = TW'(OS / 2 - 1);
    localparam logic [TW-1:0] T_FULL = TW'(OS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DW - 1);
    localparam logic [BW-1:0] B_EXTRA = BW'(DW);

    as_state_e     state_q;
    logic [TW-1:0] tcnt_q;
    logic [BW-1:0] bcnt_q;
    logic [DW-1:0] shreg_q;
    logic          extra_q;
    logic          line_q;
    logic          fall;

    assign fall = line_q && !line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= AS_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            shreg_q <= '0;
            extra_q <= 1'b0;
            line_q  <= 1'b1;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            line_q <= line;
            done   <= 1'b0;
            if (!en) begin
                state_q <= AS_IDLE;
                tcnt_q  <= '0;
                bcnt_q  <= '0;
            end else begin
                unique case (state_q)
                    AS_IDLE: begin
                        if (fall) begin
                            state_q <= AS_START;
                            tcnt_q  <= '0;
                        end
                    end
                    AS_START: begin
                        if (tick) begin
                            if (tcnt_q == T_HALF) begin
                                tcnt_q <= '0;
                                bcnt_q <= '0;
                                state_q <= line ? AS_IDLE : AS_BITS;
                            end else begin
                                tcnt_q <= tcnt_q + 1'b1;
                            end
                        end
                    end
                    AS_BITS: begin
                        if (tick) begin
                            if (tcnt_q == T_FULL) begin
                                tcnt_q <= '0;
                                bcnt_q <= bcnt_q + 1'b1;
                                if (bcnt_q < B_EXTRA) shreg_q <= {line, shreg_q[DW-1:1]};
                                else                  extra_q <= line;
                                if ((bcnt_q == B_LAST && !extra_en) || bcnt_q == B_EXTRA)
                                    state_q <= AS_STOP;
                            end else begin
                                tcnt_q <= tcnt_q + 1'b1;
                            end
                        end
                    end
                    AS_STOP: begin
                        if (tick) begin
                            if (tcnt_q == T_FULL) begin
                                tcnt_q        <= '0;
                                state_q       <= AS_IDLE;
                                done          <= 1'b1;
                                frame.data    <= shreg_q;
                                frame.extra   <= extra_en ? extra_q : 1'b0;
                                frame.frm_bad <= !line;
                            end else begin
                                tcnt_q <= tcnt_q + 1'b1;
                            end
                        end
                    end
                    default: state_q <= AS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_rx_clksync.sv
module sio_rx_clksync
    import sio_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sclk_s,
    input  logic          sdat_s,
    output logic          done,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] C_LAST = CW'(DW - 1);

    logic          sclk_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shreg_q;
    logic          rise;

    assign rise = sclk_s && !sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            done    <= 1'b0;
            data    <= '0;
        end else begin
            sclk_q <= sclk_s;
            done   <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
            end else if (rise) begin
                shreg_q <= {sdat_s, shreg_q[DW-1:1]};
                if (cnt_q == C_LAST) begin
                    cnt_q <= '0;
                    done  <= 1'b1;
                    data  <= {sdat_s, shreg_q[DW-1:1]};
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
    import sio_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  rx_mode_e      mode,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          done,
    input  frame_t        frame,
    input  logic          rd,
    input  logic          clr,
    output status_t       st,
    output logic [DW-1:0] data
);
    logic full_eff;
    logic pe_new;
    logic fe_new;

    // a read in the same cycle frees the register for the incoming byte
    assign full_eff = st.full && !rd;
    assign pe_new   = (mode == MODE_ASYNC || mode == MODE_RSVD) && par_en
                      && parity_mismatch(frame.data, frame.extra, par_odd);
    assign fe_new   = is_async(mode) && frame.frm_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            data <= '0;
        end else begin
            if (rd)  st.full <= 1'b0;
            if (clr) begin
                st.perr <= 1'b0;
                st.ovr  <= 1'b0;
                st.ferr <= 1'b0;
            end
            if (done) begin
                st.full <= 1'b1;
                if (full_eff) begin
                    st.ovr <= 1'b1;
                end else begin
                    data    <= frame.data;
                    st.addr <= (mode == MODE_MPROC) ? frame.extra : 1'b0;
                    if (pe_new) st.perr <= 1'b1;
                    if (fe_new) st.ferr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       sclk,
    input  logic       rd_pulse,
    input  logic       err_clr,
    input  logic       ie_rx,
    input  logic       ie_err,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       err_par,
    output logic       err_ovr,
    output logic       err_frm,
    output logic       addr_flag,
    output logic       irq_rx,
    output logic       irq_err
);
    rx_mode_e      mode_e;
    logic [1:0]    sync_out;
    logic          line_s;
    logic          sclk_s;
    logic          as_done;
    frame_t        as_frame;
    logic          cs_done;
    logic [DW-1:0] cs_data;
    logic          frame_done;
    frame_t        frame_sel;
    status_t       st;
    logic          extra_en;

    assign mode_e   = rx_mode_e'(mode);
    assign extra_en = (mode_e == MODE_MPROC) || par_en;

    sio_rx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sclk, rxd}),
        .dout (sync_out)
    );
    assign line_s = sync_out[0];
    assign sclk_s = sync_out[1];

    sio_rx_async #(.OS(OSR)) u_async (
        .clk      (clk),
        .rst      (rst),
        .en       (is_async(mode_e)),
        .tick     (os_tick),
        .line     (line_s),
        .extra_en (extra_en),
        .done     (as_done),
        .frame    (as_frame)
    );

    sio_rx_clksync u_csync (
        .clk    (clk),
        .rst    (rst),
        .en     (mode_e == MODE_SYNC),
        .sclk_s (sclk_s),
        .sdat_s (line_s),
        .done   (cs_done),
        .data   (cs_data)
    );

    assign frame_done = as_done || cs_done;
    always_comb begin
        if (cs_done) frame_sel = '{data: cs_data, extra: 1'b0, frm_bad: 1'b0};
        else         frame_sel = as_frame;
    end

    sio_rx_status u_status (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_e),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (frame_done),
        .frame   (frame_sel),
        .rd      (rd_pulse),
        .clr     (err_clr),
        .st      (st),
        .data    (rx_data)
    );

    assign rx_full   = st.full;
    assign err_par   = st.perr;
    assign err_ovr   = st.ovr;
    assign err_frm   = st.ferr;
    assign addr_flag = st.addr;
    assign irq_rx    = ie_rx && st.full;
    assign irq_err   = ie_err && (st.perr || st.ovr || st.ferr);
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       rd_pulse,
    input logic       err_clr,
    input logic       frame_done,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       err_par,
    input logic       err_ovr,
    input logic       err_frm,
    input logic       ie_err,
    input logic       irq_err
);
    // R4: no parity error appears in address-bit mode
    p_mp_no_parity_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !err_par) |=> !err_par);

    // R6: no parity or framing error appears in synchronous mode
    p_sync_no_perr_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !err_par && !err_frm) |=> !(err_par || err_frm));

    // R5: a framing error rises together with the full flag
    p_frm_with_full_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_frm) |-> rx_full);

    // R7: an overrun keeps the unread byte
    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_ovr) |-> $stable(rx_data));

    // R8: a read with no frame arriving empties the register
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_pulse && !frame_done) |=> !rx_full);

    // R9: a clear with no frame arriving drops every error flag
    p_clear_errs_r9: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !frame_done) |=> !(err_par || err_ovr || err_frm));

    // R10: the error request needs its enable
    p_irq_err_gated_r10: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> ie_err);
endmodule

bind sio_rx sio_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .rd_pulse   (rd_pulse),
    .err_clr    (err_clr),
    .frame_done (frame_done),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .err_par    (err_par),
    .err_ovr    (err_ovr),
    .err_frm    (err_frm),
    .ie_err     (ie_err),
    .irq_err    (irq_err)
);

// File: tb/tb_sio_rx.sv
module tb_sio_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       sclk = 1'b0;
    logic       rd_pulse = 1'b0;
    logic       err_clr = 1'b0;
    logic       ie_rx = 1'b0;
    logic       ie_err = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_par, err_ovr, err_frm, addr_flag, irq_rx, irq_err;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sio_rx dut (
        .clk(clk), .rst(rst), .mode(mode), .par_en(par_en), .par_odd(par_odd),
        .os_tick(os_tick), .rxd(rxd), .sclk(sclk), .rd_pulse(rd_pulse),
        .err_clr(err_clr), .ie_rx(ie_rx), .ie_err(ie_err), .rx_data(rx_data),
        .rx_full(rx_full), .err_par(err_par), .err_ovr(err_ovr), .err_frm(err_frm),
        .addr_flag(addr_flag), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic at_neg;
        @(negedge clk);
    endtask

    task automatic send_async(input logic [7:0] d, input logic has9,
                              input logic b9, input logic stopb);
        rxd = 1'b0; cyc(BIT_CYC);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; cyc(BIT_CYC);
        end
        if (has9) begin
            rxd = b9; cyc(BIT_CYC);
        end
        rxd = stopb; cyc(BIT_CYC);
        rxd = 1'b1; cyc(20);
    endtask

    task automatic send_sync(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; rxd = d[i]; cyc(4);
            sclk = 1'b1; cyc(4);
        end
        sclk = 1'b0; cyc(8);
    endtask

    task automatic pulse_rd;
        rd_pulse = 1'b1; cyc(1); rd_pulse = 1'b0; cyc(1);
    endtask

    task automatic pulse_clr;
        err_clr = 1'b1; cyc(1); err_clr = 1'b0; cyc(1);
    endtask

    task automatic t_reset;
        at_neg();
        chk("R11", "data", rx_data, 0);
        chk("R11", "flags", {rx_full, err_par, err_ovr, err_frm, addr_flag}, 0);
        chk("R11", "irqs", {irq_rx, irq_err}, 0);
    endtask

    task automatic t_normal;
        mode = 2'b00; par_en = 1'b0; ie_rx = 1'b0;
        send_async(8'hA5, 1'b0, 1'b0, 1'b1);
        at_neg();
        chk("R1", "data", rx_data, 8'hA5);
        chk("R1", "full", rx_full, 1);
        chk("R1", "no errors", {err_par, err_ovr, err_frm}, 0);
        chk("R10", "irq_rx disabled", irq_rx, 0);
        ie_rx = 1'b1; #1;
        chk("R10", "irq_rx enabled", irq_rx, 1);
        err_clr = 1'b1; cyc(1); err_clr = 1'b0; at_neg();
        chk("R9", "clear keeps full", rx_full, 1);
        pulse_rd(); at_neg();
        chk("R8", "read clears full", rx_full, 0);
        chk("R10", "irq_rx drops", irq_rx, 0);
    endtask

    task automatic t_glitch;
        rxd = 1'b0; cyc(4); rxd = 1'b1; cyc(200);
        at_neg();
        chk("R2", "glitch rejected", rx_full, 0);
        send_async(8'h3E, 1'b0, 1'b0, 1'b1);
        at_neg();
        chk("R2", "next frame intact", rx_data, 8'h3E);
        pulse_rd();
    endtask

    task automatic t_parity;
        mode = 2'b00; par_en = 1'b1; par_odd = 1'b0; ie_err = 1'b1;
        send_async(8'h3C, 1'b1, 1'b0, 1'b1);
        at_neg();
        chk("R3", "even good", err_par, 0);
        pulse_rd();
        send_async(8'h3C, 1'b1, 1'b1, 1'b1);
        at_neg();
        chk("R3", "even bad", err_par, 1);
        chk("R3", "full with perr", rx_full, 1);
        chk("R10", "irq_err", irq_err, 1);
        pulse_rd(); at_neg();
        chk("R8", "read keeps perr", err_par, 1);
        pulse_clr(); at_neg();
        chk("R9", "clear perr", err_par, 0);
        chk("R10", "irq_err drops", irq_err, 0);
        par_odd = 1'b1;
        send_async(8'h01, 1'b1, 1'b0, 1'b1);
        at_neg();
        chk("R3", "odd good", err_par, 0);
        pulse_rd();
        send_async(8'h01, 1'b1, 1'b1, 1'b1);
        at_neg();
        chk("R3", "odd bad", err_par, 1);
        pulse_rd(); pulse_clr();
        par_odd = 1'b0;
    endtask

    task automatic t_mproc;
        mode = 2'b01; par_en = 1'b1;
        send_async(8'h55, 1'b1, 1'b1, 1'b1);
        at_neg();
        chk("R4", "data", rx_data, 8'h55);
        chk("R4", "addr bit set", addr_flag, 1);
        chk("R4", "no parity err", err_par, 0);
        pulse_rd();
        send_async(8'h12, 1'b1, 1'b0, 1'b1);
        at_neg();
        chk("R4", "addr bit clear", addr_flag, 0);
        chk("R4", "data 2", rx_data, 8'h12);
        pulse_rd();
        send_async(8'h0F, 1'b1, 1'b1, 1'b0);
        at_neg();
        chk("R5", "mp framing", err_frm, 1);
        pulse_rd(); pulse_clr();
        par_en = 1'b0;
    endtask

    task automatic t_frame;
        mode = 2'b00; par_en = 1'b0;
        send_async(8'h77, 1'b0, 1'b0, 1'b0);
        at_neg();
        chk("R5", "framing err", err_frm, 1);
        chk("R5", "full with ferr", rx_full, 1);
        pulse_clr(); at_neg();
        chk("R9", "clear ferr", err_frm, 0);
        pulse_rd();
    endtask

    task automatic t_overrun;
        mode = 2'b00;
        send_async(8'h11, 1'b0, 1'b0, 1'b1);
        send_async(8'h22, 1'b0, 1'b0, 1'b1);
        at_neg();
        chk("R7", "overrun flag", err_ovr, 1);
        chk("R7", "old byte kept", rx_data, 8'h11);
        pulse_clr(); at_neg();
        chk("R9", "clear ovr", err_ovr, 0);
        pulse_rd();
    endtask

    task automatic t_sync;
        mode = 2'b10; par_en = 1'b1; cyc(4);
        send_sync(8'h96);
        at_neg();
        chk("R6", "data", rx_data, 8'h96);
        chk("R6", "full", rx_full, 1);
        chk("R6", "no perr/ferr", {err_par, err_frm}, 0);
        send_sync(8'h4B);
        at_neg();
        chk("R7", "sync overrun", err_ovr, 1);
        chk("R7", "sync old kept", rx_data, 8'h96);
        pulse_rd(); pulse_clr();
        send_sync(8'h4B);
        at_neg();
        chk("R6", "data 2", rx_data, 8'h4B);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        t_reset();
        t_normal();
        t_glitch();
        t_parity();
        t_mproc();
        t_frame();
        t_overrun();
        t_sync();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule